// File: doc/BRIEF.md
# Triggered Dual Delay Pulse Generator

This block times two downstream events from one trigger. A rising edge on the selected trigger line (an on-chip source or an off-chip pin) starts a 16-bit up-counter from zero. Two compare registers are matched against the running count. Each match produces a one-cycle pulse on its own output. A third output carries the OR of the two pulses, so a single trigger can schedule two events on one line.

A window output is set by the first compare and cleared by the second. Its edges therefore land on exact counts, which suits gating a comparison window. The counter either stops at its modulo value and waits for a new trigger (single-shot) or wraps to zero and keeps running (continuous). A bypass control skips the counter and sends the selected trigger level straight to the pulse outputs.

All inputs are treated as synchronous to the block clock. Mode and compare inputs are expected to be changed only while the counter is idle.

Top module: `trig_delay_gen`

## Requirements
- R1: While reset is held and on the first cycle after it is released, pulse_a, pulse_b, pulse_or and window are all low.
- R2: With trig_sel = 0 the counter is started by a rising edge of trig_int, and with trig_sel = 1 by a rising edge of trig_ext. Activity on the line that is not selected starts nothing.
- R3: pulse_a is high for exactly the one cycle in which the running count equals delay_a. The count is 0 in the cycle right after the clock edge that samples the trigger rise, and it increases by one per cycle.
- R4: pulse_b obeys the same rule as R3, using delay_b.
- R5: pulse_or equals pulse_a OR pulse_b in every cycle.
- R6: With continuous = 0 the counter runs through count = modulo and then stops. It produces no further pulses until a new trigger edge arrives, and a delay larger than modulo never fires.
- R7: With continuous = 1 the count returns to 0 in the cycle after it equals modulo. Both pulses therefore repeat every modulo+1 cycles.
- R8: A trigger rising edge that arrives while the counter is running has no effect on the count or on the pulses.
- R9: window goes high in the cycle after pulse_a and low in the cycle after pulse_b. When both pulses occur in the same cycle it goes low, and otherwise it holds its value.
- R10: While bypass = 1, pulse_a, pulse_b and pulse_or follow the selected trigger level in the same cycle, window is held low, and the counter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_sel | input | 1 | 0 selects trig_int, 1 selects trig_ext |
| trig_int | input | 1 | On-chip trigger source |
| trig_ext | input | 1 | Off-chip trigger source, already synchronised |
| continuous | input | 1 | 1 wraps the counter at modulo, 0 stops it there |
| bypass | input | 1 | 1 sends the selected trigger straight to the pulse outputs |
| modulo | input | 16 | Last count value of a period |
| delay_a | input | 16 | Count at which pulse_a fires and the window opens |
| delay_b | input | 16 | Count at which pulse_b fires and the window closes |
| pulse_a | output | 1 | First delayed pulse |
| pulse_b | output | 1 | Second delayed pulse |
| pulse_or | output | 1 | OR of pulse_a and pulse_b |
| window | output | 1 | Level set by pulse_a and cleared by pulse_b |

## Verification
Single-shot runs use distinct delays, equal delays, a zero delay and a delay beyond modulo. Together they separate an off-by-one count origin, the clear-wins rule and the stop at modulo. A continuous run shows whether the counter wraps or parks. A run with a trigger that drops and rises again mid-count shows whether retriggering is ignored. A toggle on the unselected line checks the source selector, and a bypass pattern checks that the trigger level passes straight through with no delay.

// File: rtl/pdg_pkg.sv
// Shared definitions for the triggered delay generator.
// Assumes: one clock domain, all inputs synchronous to it.
package pdg_pkg;
    // Number of independent delay compare channels
    localparam int unsigned NUM_DLY = 2;
    // Index of the channel that opens the window
    localparam int unsigned CH_SET  = 0;
    // Index of the channel that closes the window
    localparam int unsigned CH_CLR  = 1;

    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } trig_src_e;
endpackage

// File: rtl/trig_front.sv
// Trigger front end: picks one of two trigger lines and flags its rising edge.
// Assumes: both lines already synchronous to clk.
module trig_front
    import pdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  trig_src_e src,
    input  logic      line_int,
    input  logic      line_ext,
    output logic      level,
    output logic      rise
);
    logic level_q;

    // Source mux
    assign level = (src == SRC_EXTERNAL) ? line_ext : line_int;

    // Remember previous level of the selected line for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/span_counter.sv
// Span counter: starts at zero on a start pulse, counts to a modulo, then
// either wraps (continuous) or parks idle (single-shot). Starts that arrive
// while running are ignored. A hold input forces it idle.
// Assumes: modulo is stable while running.
module span_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             hold,
    input  logic             wrap_en,
    input  logic [CNT_W-1:0] last_val,
    output logic             running,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Run/stop control and count progression
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            running <= 1'b0;
            count   <= '0;
        end else if (!running) begin
            if (start) begin
                running <= 1'b1;
                count   <= '0;
            end
        end else if (count == last_val) begin
            if (wrap_en) count   <= '0;
            else         running <= 1'b0;
        end else begin
            count <= count + ONE;
        end
    end
endmodule

// File: rtl/dly_match.sv
// Delay compare bank: one equality match per channel against the running
// count; a match only counts while the counter is running.
// Assumes: delays are stable while running.
module dly_match #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned NCH   = 2
) (
    input  logic                      running,
    input  logic [CNT_W-1:0]          count,
    input  logic [NCH-1:0][CNT_W-1:0] delays,
    output logic [NCH-1:0]            hit
);
    // One comparator per channel
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign hit[ch] = running && (count == delays[ch]);
    end
endmodule

// File: rtl/window_gen.sv
// Window register: set by one pulse, cleared by another; clear wins, and a
// force-clear input holds it low.
// Assumes: set and clr are single-cycle strobes.
module window_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic force_clr,
    input  logic set,
    input  logic clr,
    output logic win
);
    // Set/clear level with clear priority
    always_ff @(posedge clk) begin
        if (!rst_n || force_clr) win <= 1'b0;
        else if (clr)            win <= 1'b0;
        else if (set)            win <= 1'b1;
    end
endmodule

// File: rtl/trig_delay_gen.sv
// Triggered dual delay generator top: trigger select and edge detect, span
// counter, two delay compares, OR output, window output and bypass path.
// Assumes: mode and delay inputs change only while the counter is idle.
module trig_delay_gen
    import pdg_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_sel,
    input  logic             trig_int,
    input  logic             trig_ext,
    input  logic             continuous,
    input  logic             bypass,
    input  logic [CNT_W-1:0] modulo,
    input  logic [CNT_W-1:0] delay_a,
    input  logic [CNT_W-1:0] delay_b,
    output logic             pulse_a,
    output logic             pulse_b,
    output logic             pulse_or,
    output logic             window
);
    logic                          trig_lvl;
    logic                          trig_rise;
    logic                          cnt_run;
    logic [CNT_W-1:0]              cnt_val;
    logic [NUM_DLY-1:0][CNT_W-1:0] dly_vec;
    logic [NUM_DLY-1:0]            dly_hit;
    logic [NUM_DLY-1:0]            out_vec;

    trig_front u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (trig_src_e'(trig_sel)),
        .line_int (trig_int),
        .line_ext (trig_ext),
        .level    (trig_lvl),
        .rise     (trig_rise)
    );

    span_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (trig_rise),
        .hold     (bypass),
        .wrap_en  (continuous),
        .last_val (modulo),
        .running  (cnt_run),
        .count    (cnt_val)
    );

    assign dly_vec[CH_SET] = delay_a;
    assign dly_vec[CH_CLR] = delay_b;

    dly_match #(.CNT_W(CNT_W), .NCH(NUM_DLY)) u_match (
        .running (cnt_run),
        .count   (cnt_val),
        .delays  (dly_vec),
        .hit     (dly_hit)
    );

    window_gen u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .force_clr (bypass),
        .set       (dly_hit[CH_SET]),
        .clr       (dly_hit[CH_CLR]),
        .win       (window)
    );

    // Bypass selects the raw trigger level for every pulse channel
    assign out_vec  = bypass ? {NUM_DLY{trig_lvl}} : dly_hit;
    assign pulse_a  = out_vec[CH_SET];
    assign pulse_b  = out_vec[CH_CLR];
    assign pulse_or = |out_vec;
endmodule

// File: rtl/trig_delay_gen_chk.sv
// Property checker for trig_delay_gen, attached by bind.
// Assumes: modulo, delays and modes are stable while a run is in progress.
module trig_delay_gen_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bypass,
    input logic [CNT_W-1:0] modulo,
    input logic             pulse_a,
    input logic             pulse_b,
    input logic             window
);
    // R3
    a_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && pulse_a && modulo != '0) |=> (bypass || !pulse_a));

    // R4
    b_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && pulse_b && modulo != '0) |=> (bypass || !pulse_b));

    // R9
    win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && pulse_a && !pulse_b) |=> window);

    // R9
    win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && pulse_b) |=> !window);

    // R10
    byp_win_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> !window);
endmodule

bind trig_delay_gen trig_delay_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bypass  (bypass),
    .modulo  (modulo),
    .pulse_a (pulse_a),
    .pulse_b (pulse_b),
    .window  (window)
);

// File: tb/sim_trig_delay_gen.sv
module sim_trig_delay_gen;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         trig_sel = 1'b0, trig_int = 1'b0, trig_ext = 1'b0;
    logic         continuous = 1'b0, bypass = 1'b0;
    logic [W-1:0] modulo = '0, delay_a = '0, delay_b = '0;
    logic         pulse_a, pulse_b, pulse_or, window;

    int errors = 0;
    int checks = 0;
    logic wcur = 1'b0;

    typedef struct {
        logic  pa;
        logic  pb;
        logic  po;
        logic  w;
        string req;
    } item_t;

    item_t q[$];

    always #2 clk = ~clk;

    trig_delay_gen #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_sel(trig_sel), .trig_int(trig_int),
        .trig_ext(trig_ext), .continuous(continuous), .bypass(bypass),
        .modulo(modulo), .delay_a(delay_a), .delay_b(delay_b),
        .pulse_a(pulse_a), .pulse_b(pulse_b), .pulse_or(pulse_or),
        .window(window)
    );

    task automatic push(input logic pa, input logic pb, input logic w, input string tag);
        item_t it;
        it.pa = pa; it.pb = pb; it.po = pa | pb; it.w = w; it.req = tag;
        q.push_back(it);
    endtask

    task automatic set_line(input bit sel, input logic v);
        if (sel) trig_ext = v;
        else     trig_int = v;
    endtask

    // Driver: one trigger run, pushing the expected outputs for every cycle
    task automatic shot(input bit cont, input bit sel, input int m, input int a,
                        input int b, input int n, input int rtg, input string tag);
        @(posedge clk); #1;
        continuous = cont; trig_sel = sel;
        modulo = W'(m); delay_a = W'(a); delay_b = W'(b);
        set_line(sel, 1'b1);
        push(1'b0, 1'b0, wcur, tag);
        for (int k = 0; k < n; k++) begin
            bit act;
            int c;
            logic pa, pb;
            @(posedge clk); #1;
            if (k == rtg)     set_line(sel, 1'b0);
            if (k == rtg + 1) set_line(sel, 1'b1);
            act = cont || (k <= m);
            c   = cont ? (k % (m + 1)) : k;
            pa  = act && (c == a);
            pb  = act && (c == b);
            push(pa, pb, wcur, tag);
            if (pb)      wcur = 1'b0;
            else if (pa) wcur = 1'b1;
        end
        @(posedge clk); #1;
        set_line(sel, 1'b0);
        if (cont) begin
            continuous = 1'b0;
            repeat (m + 3) @(posedge clk);
            #1;
            wcur = 1'b0;
        end
    endtask

    // Monitor: pops one expected item per cycle and compares
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t e;
            e = q.pop_front();
            checks++;
            if (pulse_a !== e.pa || pulse_b !== e.pb || pulse_or !== e.po || window !== e.w) begin
                errors++;
                $display("FAIL %s: a/b/or/win got %b%b%b%b expected %b%b%b%b",
                         e.req, pulse_a, pulse_b, pulse_or, window, e.pa, e.pb, e.po, e.w);
            end
        end
    end

    // Watchdog
    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs low during reset
        checks++;
        if ({pulse_a, pulse_b, pulse_or, window} !== 4'b0) begin
            errors++;
            $display("FAIL R1: got %b expected 0000", {pulse_a, pulse_b, pulse_or, window});
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        push(1'b0, 1'b0, 1'b0, "R1");

        // R2 R3 R4 R5 R9: internal trigger, distinct delays
        shot(1'b0, 1'b0, 9, 2, 6, 14, -1, "R2 R3 R4 R5 R9 single-shot internal");
        // R9 clear wins with equal delays, external trigger (R2)
        shot(1'b0, 1'b1, 7, 5, 5, 10, -1, "R2 R9 equal delays");
        // R6: delay_b beyond modulo never fires, window stays open
        shot(1'b0, 1'b0, 8, 4, 12, 12, -1, "R6 delay past modulo");
        // R8: retrigger mid-run ignored
        shot(1'b0, 1'b0, 8, 7, 1, 13, 3, "R8 retrigger ignored");
        // R7: continuous wrap
        shot(1'b1, 1'b0, 5, 1, 3, 15, -1, "R7 continuous");
        // R3 with zero delay
        shot(1'b0, 1'b1, 3, 0, 3, 6, -1, "R3 zero delay");

        // R2: unselected line toggles, nothing starts
        @(posedge clk); #1;
        trig_sel = 1'b0; modulo = W'(4); delay_a = '0; delay_b = W'(2);
        trig_ext = 1'b1;
        push(1'b0, 1'b0, wcur, "R2 unselected line");
        for (int k = 0; k < 6; k++) begin
            @(posedge clk); #1;
            push(1'b0, 1'b0, wcur, "R2 unselected line");
        end
        @(posedge clk); #1;
        trig_ext = 1'b0;

        // R10: bypass follows selected level
        @(posedge clk); #1;
        bypass = 1'b1; trig_sel = 1'b1;
        push(1'b0, 1'b0, wcur, "R10 bypass");
        for (int k = 0; k < 6; k++) begin
            logic v;
            v = (k == 0 || k == 1 || k == 3);
            @(posedge clk); #1;
            trig_ext = v;
            push(v, v, 1'b0, "R10 bypass");
        end
        @(posedge clk); #1;
        trig_ext = 1'b0;
        push(1'b0, 1'b0, 1'b0, "R10 bypass");
        @(posedge clk); #1;
        bypass = 1'b0;
        wcur = 1'b0;

        // Back to delay mode after bypass
        shot(1'b0, 1'b0, 6, 2, 4, 9, -1, "R3 R4 R9 after bypass");

        wait (q.size() == 0);
        @(posedge clk); #1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule